// File: doc/BRIEF.md
# QAM and QPSK symbol mapper

The block turns a serial stream of input digits into signed fixed-point in-phase (I) and quadrature (Q) amplitudes. Each digit is a binary 0 or 1, or a discontinuous-transmission (DTX) marker carried on a separate flag. A mode input picks QPSK (two digits per symbol), 16QAM (four digits) or 64QAM (six digits). Inside each group the digits alternate between the I and Q branches. The earliest digit a branch receives is its sign, and the later digits choose the magnitude.

Amplitudes use 12-bit two's complement, with unit amplitude stored as 1024 and every level rounded to the nearest integer. A single internal state machine collects the digits. It has two states. ST_EMPTY means no digit of the current group is held. ST_FILL means a group is partly collected. It has four transitions:
- T_START (ST_EMPTY to ST_FILL): the first digit arrives.
- T_COMPLETE (ST_FILL to ST_EMPTY): the last digit arrives.
- T_ABORT (ST_FILL to ST_EMPTY): a frame start arrives with no digit.
- T_RESTART (ST_FILL to ST_FILL): a frame start arrives together with a digit.

A complete group produces one registered output strobe with its I/Q pair. A frame-start pulse realigns the grouping, so the next digit always lands on the I branch.

Top module: `qam_symbol_mapper`

## Requirements
- R1: While rst_n is low, and right after it is released, out_valid is 0 and out_i and out_q are 0.
- R2: Mode code 0 selects QPSK, and the reserved code 3 also selects QPSK. Two digits form a group: the first goes to I and the second to Q. Digit 0 gives +1024, digit 1 gives -1024 and a DTX digit gives 0.
- R3: Mode code 1 selects 16QAM with digits n0..n3. I uses n0 as sign and n2 as magnitude; Q uses n1 as sign and n3 as magnitude. Sign 0 means positive. Magnitude bit 0 gives 458 and 1 gives 1374.
- R4: Mode code 2 selects 64QAM with digits n0..n5. I uses sign n0 and magnitude code {n2,n4}; Q uses sign n1 and magnitude code {n3,n5}. Sign 0 means positive. The codes map as 00 to 670, 01 to 223, 10 to 1117 and 11 to 1564.
- R5: In 64QAM, a DTX digit is read as binary 0.
- R6: A 16QAM group whose four digits are all DTX yields out_i = 0 and out_q = 0.
- R7: In a 16QAM branch pair, (n0,n2) for I or (n1,n3) for Q, a single DTX digit takes the value of the other digit in the same pair.
- R8: A 16QAM pair made entirely of DTX takes the other pair's values in the same order, after that pair's own R7 filling. Non-DTX digits keep their values.
- R9: out_valid pulses high for exactly one cycle per completed group, in the cycle after the group's last digit is accepted. out_i and out_q hold their values whenever out_valid is low.
- R10: The mode is sampled only with the first digit of a group. Mode changes later in the same group have no effect.
- R11: A frame_start pulse discards any partial group. A digit accepted in the same cycle becomes digit 0 of a new group, and that cycle produces no output.
- R12: Cycles with in_valid low consume no digit and produce no strobe, whatever in_bit, in_dtx and mode carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Constellation select: 0 QPSK, 1 16QAM, 2 64QAM, 3 QPSK |
| frame_start | input | 1 | Frame boundary pulse; restarts the digit grouping |
| in_valid | input | 1 | A digit is present on in_bit/in_dtx this cycle |
| in_bit | input | 1 | Binary value of the digit |
| in_dtx | input | 1 | Digit is a DTX marker (in_bit is then ignored except as R5/R7/R8 say) |
| out_valid | output | 1 | One-cycle strobe: out_i/out_q carry a new symbol |
| out_i | output | 12 | Signed I amplitude, 1024 = 1.0 |
| out_q | output | 12 | Signed Q amplitude, 1024 = 1.0 |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a frame start arriving on the very digit that would complete a group. The design must take T_RESTART instead of T_COMPLETE, so there is no strobe, and that digit opens a new group. The bench sets this up directly at the last digit of a 16QAM group. The random stream also hits it now and then, and the reference model rules on it by restarting its own count.

The second pair is a mode change arriving with the first digit of a group, or in the middle of one. The bench changes the mode mid-group on purpose. It judges the result by the group length and the levels it expects from the mode that was sampled with the group's first digit.

// File: rtl/qam_map_pkg.sv
package qam_map_pkg;

    typedef enum logic [1:0] {
        MD_QPSK = 2'd0,
        MD_Q16  = 2'd1,
        MD_Q64  = 2'd2,
        MD_RSV  = 2'd3
    } map_mode_e;

    localparam int GRP_MAX = 6;

    // Number of digits that make up one group in a given mode
    function automatic int grp_len(map_mode_e m);
        case (m)
            MD_Q16:  return 4;
            MD_Q64:  return 6;
            default: return 2;
        endcase
    endfunction

    // Level given in units of 1/10000, scaled to `one` and rounded to nearest
    function automatic int amp_round(int ten_thousandths, int one);
        return (ten_thousandths * one + 5000) / 10000;
    endfunction

endpackage

// File: rtl/qam_grp_collect.sv
module qam_grp_collect
    import qam_map_pkg::*;
#(
    parameter int GRP_W = GRP_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             in_dtx,
    output logic             grp_done,
    output map_mode_e        grp_mode,
    output logic [GRP_W-1:0] grp_bits,
    output logic [GRP_W-1:0] grp_dtx
);
    localparam int CNT_W = $clog2(GRP_W);

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FILL  = 1'b1
    } col_state_e;

    col_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;
    logic [GRP_W-1:0] bits_q, dtx_q;
    map_mode_e        mode_q;
    map_mode_e        cur_mode;
    logic             last;

    // Slot the incoming digit occupies, and the mode governing its group
    always_comb begin
        idx      = (state_q == ST_EMPTY || frame_start) ? '0 : cnt_q;
        cur_mode = (idx == '0) ? map_mode_e'(mode) : mode_q;
        last     = in_valid && ((int'(idx) + 1) == grp_len(cur_mode));
    end

    // Transitions: T_START, T_COMPLETE, T_ABORT, T_RESTART
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid && !last) state_d = ST_FILL;          // T_START
            end
            ST_FILL: begin
                if (frame_start)
                    state_d = in_valid ? ST_FILL : ST_EMPTY;       // T_RESTART / T_ABORT
                else if (last)
                    state_d = ST_EMPTY;                            // T_COMPLETE
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bits_q <= '0;
            dtx_q  <= '0;
            mode_q <= MD_QPSK;
        end else if (in_valid) begin
            for (int p = 0; p < GRP_W; p++) begin
                if (idx == CNT_W'(p)) begin
                    bits_q[p] <= in_bit;
                    dtx_q[p]  <= in_dtx;
                end
            end
            cnt_q <= last ? '0 : idx + 1'b1;
            if (idx == '0) mode_q <= cur_mode;
        end else if (frame_start) begin
            cnt_q <= '0;
        end
    end

    // Group view with the digit of this cycle merged in
    always_comb begin
        grp_done = last;
        grp_mode = cur_mode;
        grp_bits = bits_q;
        grp_dtx  = dtx_q;
        for (int p = 0; p < GRP_W; p++) begin
            if (in_valid && idx == CNT_W'(p)) begin
                grp_bits[p] = in_bit;
                grp_dtx[p]  = in_dtx;
            end
        end
    end

endmodule

// File: rtl/qam_dtx_fill.sv
module qam_dtx_fill (
    input  logic [3:0] bits,
    input  logic [3:0] dtx,
    output logic [3:0] fbits,
    output logic       all_dtx
);
    // Branch pairs: I = (0,2), Q = (1,3)
    logic [3:0] own;
    logic [1:0] pair_void;

    always_comb begin
        own = bits;
        for (int br = 0; br < 2; br++) begin
            if (dtx[br] && !dtx[br+2]) own[br]   = bits[br+2];
            if (dtx[br+2] && !dtx[br]) own[br+2] = bits[br];
            pair_void[br] = dtx[br] & dtx[br+2];
        end
    end

    always_comb begin
        fbits   = own;
        all_dtx = &dtx;
        for (int br = 0; br < 2; br++) begin
            if (pair_void[br] && !pair_void[1-br]) begin
                fbits[br]   = own[1-br];
                fbits[br+2] = own[3-br];
            end
        end
    end

endmodule

// File: rtl/qam_level_enc.sv
module qam_level_enc
    import qam_map_pkg::*;
#(
    parameter int AMP_W   = 12,
    parameter int AMP_ONE = 1024
) (
    input  map_mode_e                 mode,
    input  logic [5:0]                bits,
    input  logic [5:0]                dtx,
    input  logic [3:0]                fbits16,
    input  logic                      void16,
    output logic signed [AMP_W-1:0]   amp_i,
    output logic signed [AMP_W-1:0]   amp_q
);
    localparam logic signed [AMP_W-1:0] LV_UNIT  = AMP_W'(AMP_ONE);
    localparam logic signed [AMP_W-1:0] LV16_LO  = AMP_W'(amp_round(4472,  AMP_ONE));
    localparam logic signed [AMP_W-1:0] LV16_HI  = AMP_W'(amp_round(13416, AMP_ONE));
    localparam logic signed [AMP_W-1:0] LV64_C00 = AMP_W'(amp_round(6547,  AMP_ONE));
    localparam logic signed [AMP_W-1:0] LV64_C01 = AMP_W'(amp_round(2182,  AMP_ONE));
    localparam logic signed [AMP_W-1:0] LV64_C10 = AMP_W'(amp_round(10911, AMP_ONE));
    localparam logic signed [AMP_W-1:0] LV64_C11 = AMP_W'(amp_round(15275, AMP_ONE));

    logic [5:0]              b64;
    logic signed [AMP_W-1:0] amp [2];

    assign b64 = bits & ~dtx;   // DTX reads as 0 in 64QAM

    for (genvar br = 0; br < 2; br++) begin : g_branch
        logic signed [AMP_W-1:0] mag;
        logic                    neg;
        always_comb begin
            mag = '0;
            neg = 1'b0;
            case (mode)
                MD_Q16: begin
                    if (!void16) begin
                        neg = fbits16[br];
                        mag = fbits16[br+2] ? LV16_HI : LV16_LO;
                    end
                end
                MD_Q64: begin
                    neg = b64[br];
                    case ({b64[br+2], b64[br+4]})
                        2'b00:   mag = LV64_C00;
                        2'b01:   mag = LV64_C01;
                        2'b10:   mag = LV64_C10;
                        default: mag = LV64_C11;
                    endcase
                end
                default: begin
                    if (!dtx[br]) begin
                        neg = bits[br];
                        mag = LV_UNIT;
                    end
                end
            endcase
            amp[br] = neg ? -mag : mag;
        end
    end

    assign amp_i = amp[0];
    assign amp_q = amp[1];

endmodule

// File: rtl/qam_symbol_mapper.sv
module qam_symbol_mapper
    import qam_map_pkg::*;
#(
    parameter int AMP_W   = 12,
    parameter int AMP_ONE = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode,
    input  logic                    frame_start,
    input  logic                    in_valid,
    input  logic                    in_bit,
    input  logic                    in_dtx,
    output logic                    out_valid,
    output logic signed [AMP_W-1:0] out_i,
    output logic signed [AMP_W-1:0] out_q
);
    logic                    grp_done;
    map_mode_e               grp_mode;
    logic [GRP_MAX-1:0]      grp_bits, grp_dtx;
    logic [3:0]              fbits16;
    logic                    void16;
    logic signed [AMP_W-1:0] amp_i, amp_q;

    qam_grp_collect #(.GRP_W(GRP_MAX)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .in_dtx      (in_dtx),
        .grp_done    (grp_done),
        .grp_mode    (grp_mode),
        .grp_bits    (grp_bits),
        .grp_dtx     (grp_dtx)
    );

    qam_dtx_fill u_fill (
        .bits    (grp_bits[3:0]),
        .dtx     (grp_dtx[3:0]),
        .fbits   (fbits16),
        .all_dtx (void16)
    );

    qam_level_enc #(.AMP_W(AMP_W), .AMP_ONE(AMP_ONE)) u_enc (
        .mode    (grp_mode),
        .bits    (grp_bits),
        .dtx     (grp_dtx),
        .fbits16 (fbits16),
        .void16  (void16),
        .amp_i   (amp_i),
        .amp_q   (amp_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= grp_done;
            if (grp_done) begin
                out_i <= amp_i;
                out_q <= amp_q;
            end
        end
    end

endmodule

// File: rtl/qam_symbol_mapper_chk.sv
module qam_symbol_mapper_chk #(
    parameter int AMP_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_start,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [AMP_W-1:0] out_i,
    input logic signed [AMP_W-1:0] out_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r9_strobe_needs_digit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

    a_r11_frame_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !out_valid);

    a_r12_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

bind qam_symbol_mapper qam_symbol_mapper_chk #(.AMP_W(AMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_i       (out_i),
    .out_q       (out_q)
);

// File: tb/qam_symbol_mapper_tb.sv
module qam_symbol_mapper_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic frame_start = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_dtx = 1'b0;
    logic out_valid;
    logic signed [11:0] out_i, out_q;

    int checks = 0;
    int fails  = 0;

    int       m_cnt  = 0;
    int       m_mode = 0;
    bit [5:0] m_b, m_d;
    int       last_i = 0, last_q = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    qam_symbol_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frame_start(frame_start),
        .in_valid(in_valid), .in_bit(in_bit), .in_dtx(in_dtx),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int glen(int md);
        if (md == 1) return 4;
        if (md == 2) return 6;
        return 2;
    endfunction

    function automatic int exp_amp(int md, bit [5:0] b, bit [5:0] d, int br);
        bit [3:0] f;
        bit [5:0] bb;
        int mag;
        if (md == 1) begin
            if (d[3:0] == 4'hF) return 0;
            f = b[3:0];
            for (int p = 0; p < 2; p++) begin
                if (d[p] && !d[p+2]) f[p] = b[p+2];
                if (d[p+2] && !d[p]) f[p+2] = b[p];
            end
            for (int p = 0; p < 2; p++) begin
                if (d[p] && d[p+2]) begin
                    f[p] = f[1-p];
                    f[p+2] = f[3-p];
                end
            end
            mag = f[br+2] ? 1374 : 458;
            return f[br] ? -mag : mag;
        end else if (md == 2) begin
            bb = b & ~d;
            case ({bb[br+2], bb[br+4]})
                2'b00:   mag = 670;
                2'b01:   mag = 223;
                2'b10:   mag = 1117;
                default: mag = 1564;
            endcase
            return bb[br] ? -mag : mag;
        end
        if (d[br]) return 0;
        return b[br] ? -1024 : 1024;
    endfunction

    task automatic push(bit b, bit d, bit fs, int md, string tag);
        bit done;
        int ei, eq;
        in_valid = 1'b1; in_bit = b; in_dtx = d; frame_start = fs; mode = 2'(md);
        @(negedge clk);
        in_valid = 1'b0; frame_start = 1'b0;
        if (fs) m_cnt = 0;
        if (m_cnt == 0) m_mode = md;
        m_b[m_cnt] = b;
        m_d[m_cnt] = d;
        m_cnt++;
        done = (m_cnt == glen(m_mode));
        if (done) begin
            ei = exp_amp(m_mode, m_b, m_d, 0);
            eq = exp_amp(m_mode, m_b, m_d, 1);
            chk({tag, " strobe"}, int'(out_valid), 1);
            chk({tag, " I"}, int'(out_i), ei);
            chk({tag, " Q"}, int'(out_q), eq);
            last_i = ei; last_q = eq;
            m_cnt = 0;
        end else begin
            chk({tag, " R9 no strobe mid-group"}, int'(out_valid), 0);
            chk({tag, " R9 hold I"}, int'(out_i), last_i);
        end
    endtask

    task automatic push_grp(int md, bit [5:0] v, bit [5:0] dm, string tag);
        for (int k = 0; k < glen(md); k++) push(v[k], dm[k], 1'b0, md, tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b0; in_bit = 1'($urandom); in_dtx = 1'($urandom);
            mode = 2'($urandom);
            @(negedge clk);
            chk("R12 idle no strobe", int'(out_valid), 0);
            chk("R9 idle hold Q", int'(out_q), last_q);
        end
    endtask

    task automatic fs_only();
        in_valid = 1'b0; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_cnt = 0;
        chk("R11 frame start alone", int'(out_valid), 0);
    endtask

    initial begin
        #(5ns * 150000);
        fails++; checks++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [5:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset I", int'(out_i), 0);
        chk("R1 reset Q", int'(out_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(out_valid), 0);

        // R2 QPSK
        push_grp(0, 6'b000010, 6'b0, "R2 qpsk 0,1");
        push_grp(0, 6'b000001, 6'b000010, "R2 qpsk dtx Q");
        push_grp(3, 6'b000010, 6'b000001, "R2 reserved code");

        // R3 all 16QAM codes (key n0n1n2n3, MSB first)
        for (int key = 0; key < 16; key++) begin
            for (int k = 0; k < 4; k++) v[k] = key[3-k];
            push_grp(1, v, 6'b0, "R3 16qam");
        end

        // R4 all 64QAM codes (key n0..n5, MSB first)
        for (int key = 0; key < 64; key++) begin
            for (int k = 0; k < 6; k++) v[k] = key[5-k];
            push_grp(2, v, 6'b0, "R4 64qam");
        end

        // R5 DTX in 64QAM reads as 0
        push_grp(2, 6'b111111, 6'b100100, "R5 64qam dtx");
        push_grp(2, 6'b111111, 6'b111111, "R5 64qam all dtx");

        // R6 16QAM all DTX
        push_grp(1, 6'b001111, 6'b001111, "R6 all dtx");
        // R7 one DTX in a pair
        push_grp(1, 6'b000100, 6'b000001, "R7 I sign from mag");
        push_grp(1, 6'b000010, 6'b001000, "R7 Q mag from sign");
        // R8 whole pair DTX copies other pair
        push_grp(1, 6'b000010, 6'b000101, "R8 I from Q");
        push_grp(1, 6'b000101, 6'b001010, "R8 Q from I");
        push_grp(1, 6'b000001, 6'b000111, "R8 after R7 fill");

        // R10 mode change mid-group ignored
        push(1'b1, 1'b0, 1'b0, 1, "R10 first digit");
        push(1'b0, 1'b0, 1'b0, 0, "R10 mode to qpsk");
        push(1'b1, 1'b0, 1'b0, 2, "R10 mode to 64");
        push(1'b1, 1'b0, 1'b0, 0, "R10 group end");

        // R11 frame start alone, and with the completing digit
        push(1'b1, 1'b0, 1'b0, 2, "R11 partial");
        push(1'b0, 1'b0, 1'b0, 2, "R11 partial");
        push(1'b1, 1'b0, 1'b0, 2, "R11 partial");
        fs_only();
        push_grp(0, 6'b000001, 6'b0, "R11 qpsk after abort");
        push(1'b0, 1'b0, 1'b0, 1, "R11 16qam");
        push(1'b1, 1'b0, 1'b0, 1, "R11 16qam");
        push(1'b1, 1'b0, 1'b0, 1, "R11 16qam");
        push(1'b1, 1'b0, 1'b1, 0, "R11 restart on last digit");
        push(1'b0, 1'b1, 1'b0, 0, "R11 restarted group");

        // R12 gaps inside a group
        push(1'b0, 1'b0, 1'b0, 1, "R12 gap");
        idle(3);
        push(1'b1, 1'b0, 1'b0, 1, "R12 gap");
        idle(2);
        push(1'b1, 1'b1, 1'b0, 1, "R12 gap");
        push(1'b0, 1'b0, 1'b0, 1, "R12 gap end");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            push(1'($urandom), ($urandom % 5) == 0, ($urandom % 40) == 0,
                 int'($urandom % 4), "R9 random");
            if (($urandom % 10) == 0) idle(1 + int'($urandom % 3));
            if (($urandom % 200) == 0) fs_only();
        end

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule